// File: doc/BRIEF.md
# Host-Commanded Self-Test Sequencer

This block runs a built-in check on a pipelined arithmetic chain and reports the number of failures to a host over a byte-wide FIFO-style link. The host writes one command byte. The sequencer then seeds a pseudo-random stimulus source and drives each stimulus word into a chain of registered multiply stages. It waits for the chain latency, then compares the chain output against an expected word that it derives arithmetically. Each mismatching word adds one to a 32-bit error count.

In single mode the block runs one pass of a fixed number of vectors, sends one report frame and returns to idle. In repeated mode it runs passes back to back and sends a report frame on a fixed cycle period, until the host sends the end command. A test-only fault input flips one chosen bit at the output of a chosen stage, so that the counting path can be exercised.

Top module: `selftest_seq`

## Requirements
- R1: After reset `rd` and `wr` are low and no byte is written to the host until a start command has been accepted.
- R2: Command bytes are read with a one-cycle `rd` pulse, issued only when `rxf_n` was low in the cycle before. Code 0x01 starts single mode, 0x02 starts repeated mode and 0x03 ends repeated mode. Every other byte, and 0x03 outside repeated mode, causes no frame and no change.
- R3: A pass applies PASS_VECS stimulus words. Each word is sampled only after all STAGES registers of the chain have updated. The expected word is the stimulus times MUL_K to the power STAGES, modulo 2^16. With no fault, a pass therefore adds 0 errors.
- R4: With `fault_en` high and `fault_stage` below STAGES, every word of a pass miscompares, whichever stage and bit are chosen. With `fault_stage` at or above STAGES, the fault has no effect.
- R5: Single mode sends exactly one frame, carrying the count of its single pass, and then returns to idle.
- R6: A frame is five bytes: the header 0xA5, then the 32-bit error count with the most significant byte first.
- R7: `wr` is high for one cycle per byte, and only when `txe_n` was low at the preceding clock edge. While `txe_n` stays high, no byte is written and the frame is held.
- R8: In repeated mode, frames start every REPORT_CYC cycles while the link is ready. Their counts are cumulative and never decrease.
- R9: After an end command, no further frames are sent. Any later start command clears the error count to zero.
- R10: The error count saturates at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxf_n | input | 1 | Low when a host command byte is waiting |
| rx_data | input | 8 | Host command byte, sampled while `rd` is high |
| rd | output | 1 | One-cycle read strobe for a command byte |
| txe_n | input | 1 | Low when the host link can take a byte |
| tx_data | output | 8 | Report byte, valid while `wr` is high |
| wr | output | 1 | One-cycle write strobe per report byte |
| fault_en | input | 1 | Test-only: enable the single-bit fault |
| fault_stage | input | $clog2(STAGES)+1 | Test-only: stage whose output is corrupted |
| fault_bit | input | 4 | Test-only: bit position that is flipped |

## Verification
The bench places a fault at the first stage, at the last stage (on the top bit) and at a middle stage. A design that sampled the chain one cycle early, or computed the expected word with the wrong power, would report nonzero counts with the fault off or miss counts with it on. Stage selectors beyond the chain must give a zero count; a selector decoded with too few bits would alias onto a real stage. The link is held busy through a whole single run: a transmitter that ignored `txe_n` would write bytes during the stall. In repeated mode the bench measures the spacing between frame headers and checks that no frame follows the end command. A design with a drifting timer would show uneven spacing. One that kept reporting after the end command would keep writing, and one that failed to clear the count on restart would carry old errors into the next single run.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_CHECK,
        ST_GEN,
        ST_SEND,
        ST_FLUSH
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_SINGLE,
        CMD_MULTI,
        CMD_END
    } cmd_e;

    localparam logic [7:0] CODE_SINGLE = 8'h01;
    localparam logic [7:0] CODE_MULTI  = 8'h02;
    localparam logic [7:0] CODE_END    = 8'h03;
    localparam logic [7:0] FRAME_HDR   = 8'hA5;
    localparam int         FRAME_LEN   = 5;

endpackage

// File: rtl/selftest_cmd.sv
module selftest_cmd
    import selftest_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxf_n,
    input  logic [7:0] rx_data,
    output logic       rd,
    output cmd_e       cmd
);

    typedef struct packed {
        logic rd;
        cmd_e cmd;
    } cmd_reg_t;

    cmd_reg_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.rd  = !rxf_n && !r_q.rd;
        r_d.cmd = CMD_NONE;
        if (r_q.rd) begin
            unique case (rx_data)
                CODE_SINGLE: r_d.cmd = CMD_SINGLE;
                CODE_MULTI:  r_d.cmd = CMD_MULTI;
                CODE_END:    r_d.cmd = CMD_END;
                default:     r_d.cmd = CMD_NONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{rd: 1'b0, cmd: CMD_NONE};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd  = r_q.rd;
    assign cmd = r_q.cmd;

    AST_RD_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rd |-> $past(!rxf_n)); // R2
    AST_RD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> !rd); // R2

endmodule

// File: rtl/selftest_stim.sv
module selftest_stim #(
    parameter int              DW     = 16,
    parameter int              STAGES = 4,
    parameter logic [DW-1:0]   MUL_K  = 16'h9E37,
    parameter logic [DW-1:0]   SEED   = 16'hACE1,
    parameter logic [DW-1:0]   TAPS   = 16'hB400
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          seed_load,
    input  logic          step,
    output logic [DW-1:0] stim,
    output logic [DW-1:0] expect_w
);

    function automatic logic [DW-1:0] pow_mod(input logic [DW-1:0] k, input int n);
        logic [DW-1:0] acc;
        acc = DW'(1);
        for (int i = 0; i < n; i++) begin
            acc = acc * k;
        end
        return acc;
    endfunction

    localparam logic [DW-1:0] GAIN = pow_mod(MUL_K, STAGES);

    typedef struct packed {
        logic [DW-1:0] lfsr;
        logic [DW-1:0] expv;
    } stim_reg_t;

    stim_reg_t     r_d, r_q;
    logic [DW-1:0] nxt;

    always_comb begin
        nxt = r_q.lfsr[0] ? ((r_q.lfsr >> 1) ^ TAPS) : (r_q.lfsr >> 1);
        r_d = r_q;
        if (seed_load) begin
            r_d.lfsr = SEED;
            r_d.expv = SEED * GAIN;
        end else if (step) begin
            r_d.lfsr = nxt;
            r_d.expv = nxt * GAIN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{lfsr: SEED, expv: SEED * GAIN};
        end else begin
            r_q <= r_d;
        end
    end

    assign stim     = r_q.lfsr;
    assign expect_w = r_q.expv;

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.lfsr != '0); // R3

endmodule

// File: rtl/selftest_chain.sv
module selftest_chain #(
    parameter int            DW     = 16,
    parameter int            STAGES = 4,
    parameter logic [DW-1:0] MUL_K  = 16'h9E37,
    localparam int           STW    = $clog2(STAGES) + 1,
    localparam int           BW     = $clog2(DW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [DW-1:0]  din,
    input  logic           fault_en,
    input  logic [STW-1:0] fault_stage,
    input  logic [BW-1:0]  fault_bit,
    output logic [DW-1:0]  dout
);

    logic [DW-1:0] stage_d [STAGES];
    logic [DW-1:0] stage_q [STAGES];
    logic [DW-1:0] flip;

    assign flip = DW'(1) << fault_bit;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [DW-1:0] src;
        logic [DW-1:0] prod;
        logic          hit;
        if (i == 0) begin : g_head
            assign src = din;
        end else begin : g_body
            assign src = stage_q[i-1];
        end
        assign prod       = src * MUL_K;
        assign hit        = fault_en && (fault_stage == STW'(i));
        assign stage_d[i] = hit ? (prod ^ flip) : prod;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign dout = stage_q[STAGES-1];

    AST_CLEAN_PROPAGATE: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_en |=> stage_q[0] == DW'($past(din) * MUL_K)); // R3

endmodule

// File: rtl/selftest_tx.sv
module selftest_tx
    import selftest_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        launch,
    input  logic [31:0] count,
    input  logic        txe_n,
    output logic        busy,
    output logic        wr,
    output logic [7:0]  tx_data
);

    localparam int SHW = 8 * FRAME_LEN;
    localparam int LW  = $clog2(FRAME_LEN + 1);

    typedef struct packed {
        logic [SHW-1:0] sh;
        logic [LW-1:0]  left;
        logic           wr;
        logic [7:0]     data;
    } tx_reg_t;

    tx_reg_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.wr = 1'b0;
        if (launch && r_q.left == '0) begin
            r_d.sh   = {FRAME_HDR, count};
            r_d.left = LW'(FRAME_LEN);
        end else if (r_q.left != '0 && !txe_n) begin
            r_d.wr   = 1'b1;
            r_d.data = r_q.sh[SHW-1 -: 8];
            r_d.sh   = r_q.sh << 8;
            r_d.left = r_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = r_q.left != '0;
    assign wr      = r_q.wr;
    assign tx_data = r_q.data;

    AST_WR_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> $past(!txe_n)); // R7
    AST_LAUNCH_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !busy); // R6
    AST_FIRST_IS_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && $past(r_q.left) == LW'(FRAME_LEN)) |-> tx_data == FRAME_HDR); // R6

endmodule

// File: rtl/selftest_seq.sv
module selftest_seq
    import selftest_pkg::*;
#(
    parameter int          STAGES     = 4,
    parameter logic [15:0] MUL_K      = 16'h9E37,
    parameter int          PASS_VECS  = 4,
    parameter int          REPORT_CYC = 1000,
    localparam int         DW         = 16,
    localparam int         STW        = $clog2(STAGES) + 1,
    localparam int         BW         = $clog2(DW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rxf_n,
    input  logic [7:0]     rx_data,
    output logic           rd,
    input  logic           txe_n,
    output logic [7:0]     tx_data,
    output logic           wr,
    input  logic           fault_en,
    input  logic [STW-1:0] fault_stage,
    input  logic [BW-1:0]  fault_bit
);

    localparam int LW = $clog2(STAGES + 1);
    localparam int VW = $clog2(PASS_VECS + 1);
    localparam int TW = $clog2(REPORT_CYC + 1);

    typedef struct packed {
        seq_state_e    st;
        logic          multi;
        logic [LW-1:0] wait_cnt;
        logic [VW-1:0] vec_cnt;
        logic [31:0]   err;
        logic [TW-1:0] tmr;
        logic          pend;
    } seq_reg_t;

    seq_reg_t      s_d, s_q;
    cmd_e          cmd;
    logic          seed_load, step, launch, busy, mismatch;
    logic [DW-1:0] stim, expect_w, chain_out;

    selftest_cmd u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rxf_n   (rxf_n),
        .rx_data (rx_data),
        .rd      (rd),
        .cmd     (cmd)
    );

    selftest_stim #(.DW(DW), .STAGES(STAGES), .MUL_K(MUL_K)) u_stim (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_load (seed_load),
        .step      (step),
        .stim      (stim),
        .expect_w  (expect_w)
    );

    selftest_chain #(.DW(DW), .STAGES(STAGES), .MUL_K(MUL_K)) u_chain (
        .clk         (clk),
        .rst_n       (rst_n),
        .din         (stim),
        .fault_en    (fault_en),
        .fault_stage (fault_stage),
        .fault_bit   (fault_bit),
        .dout        (chain_out)
    );

    selftest_tx u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .count   (s_q.err),
        .txe_n   (txe_n),
        .busy    (busy),
        .wr      (wr),
        .tx_data (tx_data)
    );

    assign mismatch = chain_out != expect_w;

    always_comb begin
        s_d       = s_q;
        seed_load = 1'b0;
        step      = 1'b0;
        launch    = 1'b0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (cmd == CMD_SINGLE || cmd == CMD_MULTI) begin
                    s_d.multi    = (cmd == CMD_MULTI);
                    s_d.err      = '0;
                    s_d.tmr      = '0;
                    s_d.pend     = 1'b0;
                    s_d.vec_cnt  = '0;
                    s_d.wait_cnt = '0;
                    seed_load    = 1'b1;
                    s_d.st       = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (s_q.wait_cnt == LW'(STAGES)) begin
                    s_d.st = ST_CHECK;
                end else begin
                    s_d.wait_cnt = s_q.wait_cnt + 1'b1;
                end
            end
            ST_CHECK: begin
                if (mismatch && s_q.err != '1) begin
                    s_d.err = s_q.err + 1'b1;
                end
                if (s_q.vec_cnt == VW'(PASS_VECS - 1)) begin
                    s_d.vec_cnt = '0;
                    s_d.st      = s_q.multi ? ST_GEN : ST_SEND;
                end else begin
                    s_d.vec_cnt = s_q.vec_cnt + 1'b1;
                    s_d.st      = ST_GEN;
                end
            end
            ST_GEN: begin
                step         = 1'b1;
                s_d.wait_cnt = '0;
                s_d.st       = ST_WAIT;
            end
            ST_SEND: begin
                launch = 1'b1;
                s_d.st = ST_FLUSH;
            end
            ST_FLUSH: begin
                if (!busy) begin
                    s_d.st = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (s_q.multi && (s_q.st == ST_WAIT || s_q.st == ST_CHECK || s_q.st == ST_GEN)) begin
            if (s_q.pend && !busy) begin
                launch   = 1'b1;
                s_d.pend = 1'b0;
            end
            if (s_q.tmr == TW'(REPORT_CYC - 1)) begin
                s_d.tmr  = '0;
                s_d.pend = 1'b1;
            end else begin
                s_d.tmr = s_q.tmr + 1'b1;
            end
            if (cmd == CMD_END) begin
                s_d.multi = 1'b0;
                s_d.pend  = 1'b0;
                s_d.st    = ST_FLUSH;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, multi: 1'b0, wait_cnt: '0, vec_cnt: '0,
                     err: '0, tmr: '0, pend: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    AST_ERR_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.err == '1 && s_q.st != ST_IDLE) |=> s_q.err == '1); // R10
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && (cmd == CMD_SINGLE || cmd == CMD_MULTI)) |=> s_q.err == '0); // R9
    AST_CHECK_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.st == ST_CHECK |-> $past(s_q.st) == ST_WAIT); // R3
    AST_IDLE_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.st == ST_IDLE |-> !launch); // R5

endmodule

// File: tb/sim_selftest_seq.sv
module sim_selftest_seq;

    localparam int STAGES = 4;
    localparam int PASSV  = 4;
    localparam int PERIOD = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxf_n = 1'b1;
    logic [7:0] rx_data = 8'h00;
    logic       rd;
    logic       txe_n = 1'b0;
    logic [7:0] tx_data;
    logic       wr;
    logic       fault_en = 1'b0;
    logic [2:0] fault_stage = 3'd0;
    logic [3:0] fault_bit = 4'd0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int nbytes = 0;
    int stall_viol = 0;
    logic txe_at_edge = 1'b0;
    logic [7:0] bytes_q [512];
    int         times_q [512];

    always #4 clk = ~clk;

    selftest_seq #(.STAGES(STAGES), .PASS_VECS(PASSV), .REPORT_CYC(PERIOD)) u0 (
        .clk(clk), .rst_n(rst_n), .rxf_n(rxf_n), .rx_data(rx_data), .rd(rd),
        .txe_n(txe_n), .tx_data(tx_data), .wr(wr), .fault_en(fault_en),
        .fault_stage(fault_stage), .fault_bit(fault_bit)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        txe_at_edge <= txe_n;
    end

    always @(negedge clk) begin
        if (wr) begin
            if (txe_at_edge) stall_viol++;
            if (nbytes < 512) begin
                bytes_q[nbytes] = tx_data;
                times_q[nbytes] = cyc;
            end
            nbytes++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] frame_count(input int i);
        return {bytes_q[i+1], bytes_q[i+2], bytes_q[i+3], bytes_q[i+4]};
    endfunction

    task automatic send_cmd(input logic [7:0] b);
        @(negedge clk);
        rx_data = b;
        rxf_n   = 1'b0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (rd) break;
        end
        rxf_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_single(input bit fe, input logic [2:0] stg, input logic [3:0] bt,
                              input logic [31:0] exp, input string req);
        int base;
        fault_en = fe; fault_stage = stg; fault_bit = bt;
        base = nbytes;
        send_cmd(8'h01);
        repeat (150) @(negedge clk);
        chk(nbytes - base == 5, "R5 frame length", nbytes - base, 5);
        chk(bytes_q[base] == 8'hA5, "R6 header", bytes_q[base], 8'hA5);
        chk(frame_count(base) == exp, req, frame_count(base), exp);
    endtask

    // {fault_en, stage[2:0], bit[3:0], expected count[7:0]}
    localparam int TV_N = 6;
    localparam logic [15:0] TV [TV_N] = '{
        {1'b0, 3'd0, 4'd0,  8'd0},
        {1'b1, 3'd0, 4'd0,  8'd4},
        {1'b1, 3'd3, 4'd15, 8'd4},
        {1'b1, 3'd2, 4'd7,  8'd4},
        {1'b1, 3'd4, 4'd3,  8'd0},
        {1'b1, 3'd7, 4'd0,  8'd0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int base, nfr;
        logic [31:0] prev;
        bit mono, spaced;

        repeat (3) @(negedge clk);
        chk(rd == 1'b0 && wr == 1'b0, "R1 reset outputs", {rd, wr}, 0);
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        chk(nbytes == 0 && rd == 1'b0, "R1 idle quiet", nbytes, 0);

        // R3 / R4 table walk
        for (int i = 0; i < TV_N; i++) begin
            run_single(TV[i][15], TV[i][14:12], TV[i][11:8], 32'(TV[i][7:0]), "R3 R4 count");
        end

        // R2: unknown codes and a stray end are ignored
        base = nbytes;
        send_cmd(8'h7F);
        send_cmd(8'h00);
        send_cmd(8'h03);
        repeat (300) @(negedge clk);
        chk(nbytes == base, "R2 ignored codes", nbytes - base, 0);

        // R7: link busy through a whole single run
        txe_n = 1'b1;
        fault_en = 1'b1; fault_stage = 3'd1; fault_bit = 4'd2;
        base = nbytes;
        send_cmd(8'h01);
        repeat (100) @(negedge clk);
        chk(nbytes == base, "R7 stalled", nbytes - base, 0);
        txe_n = 1'b0;
        repeat (30) @(negedge clk);
        chk(nbytes - base == 5 && frame_count(base) == 32'd4, "R7 resumed frame",
            frame_count(base), 4);

        // R8: repeated mode
        fault_en = 1'b1; fault_stage = 3'd1; fault_bit = 4'd9;
        base = nbytes;
        send_cmd(8'h02);
        repeat (3 * PERIOD + 60) @(negedge clk);
        send_cmd(8'h03);
        repeat (20) @(negedge clk);
        nfr = (nbytes - base) / 5;
        chk((nbytes - base) % 5 == 0 && nfr >= 3, "R8 frame count", nfr, 3);
        mono = 1'b1; spaced = 1'b1; prev = 0;
        for (int f = 0; f < nfr; f++) begin
            if (bytes_q[base + 5*f] != 8'hA5) mono = 1'b0;
            if (frame_count(base + 5*f) < prev) mono = 1'b0;
            prev = frame_count(base + 5*f);
            if (f > 0 && times_q[base + 5*f] - times_q[base + 5*(f-1)] != PERIOD) spaced = 1'b0;
        end
        chk(mono && prev > 0, "R8 cumulative counts", prev, 1);
        chk(spaced, "R8 period", times_q[base + 5], times_q[base] + PERIOD);

        // R9: no frames after end, restart clears count
        base = nbytes;
        repeat (2 * PERIOD + 50) @(negedge clk);
        chk(nbytes == base, "R9 silent after end", nbytes - base, 0);
        run_single(1'b0, 3'd0, 4'd0, 32'd0, "R9 count cleared");

        chk(stall_viol == 0, "R7 write only when ready", stall_viol, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule